// File: doc/BRIEF.md
# Row Timing Engine with Row-by-Row Erase Sequencer

This block paces a sample-based storage array one row at a time. In sample mode (record or playback) it counts sample-rate ticks. For most of each row it holds an active-low row-end marker high. It drives the marker low for a fixed number of ticks at the end of the row, and the next row begins when the marker rises again. In erase mode it holds each row for a full row of ticks and then gives a short low pulse. That pulse is measured in system clocks, and the next row starts on its rising edge.

A sequence starts from a command address. The low bits of that address are dropped, so the sequence always begins on a row boundary. It then moves forward one row per marker cycle. A stop command (byte 0x80) ends the sequence at the end of the row it applies to. The sequence also ends after the last row of the array. While idle, the marker is held high and the busy flag is low.

States: IDLE (marker high, not busy), PLAY_HI (sample row, marker high), PLAY_LO (sample row end, marker low), ERASE_HI (row being erased, marker high) and ERASE_LO (erase row-end pulse, marker low). Transitions:
- start: IDLE to PLAY_HI or ERASE_HI.
- mark: PLAY_HI to PLAY_LO, and ERASE_HI to ERASE_LO.
- advance: PLAY_LO to PLAY_HI, and ERASE_LO to ERASE_HI.
- finish: PLAY_LO or ERASE_LO to IDLE, on a stop or at the last row.

Top module: `row_clock_seq`

## Requirements
- R1: After a synchronous active-high reset, `rac_n` is 1, `busy` is 0 and `row_idx` is 0.
- R2: A `start` pulse in IDLE loads `row_idx` with `start_addr[15:5]`, so bits [4:0] are ignored, and raises `busy` on the next clock edge. `erase_mode` = 1 selects erase mode and 0 selects sample mode.
- R3: A `start` is ignored when the decoded row is 1888 or more, and also when `busy` is already 1. In both cases `row_idx` and `busy` are unchanged.
- R4: In sample mode, `rac_n` stays high for ROW_TICKS-LOW_TICKS sample ticks (default 1984) and then low for LOW_TICKS ticks (default 64). Clocks without `tick` do not advance the row.
- R5: In sample mode, `row_idx` increments on the clock edge where `rac_n` returns high.
- R6: In erase mode, `rac_n` stays high for ROW_TICKS ticks and then low for ceil(ERASE_LOW_NS*CLK_MHZ/1000) system clocks, with a minimum of 1. At the defaults (250 ns, 50 MHz) this is 13 clocks.
- R7: In erase mode, `row_idx` increments on the clock edge where `rac_n` rises, and the next row starts there.
- R8: A command with `cmd_byte` = 0x80 and `cmd_valid` = 1, given while a row is active, makes that row the last one. `busy` falls on the same edge where `rac_n` returns high, and `row_idx` stays on that row. Any other byte has no effect.
- R9: A stop command given while `rac_n` is low in erase mode applies to the row that starts on the following rising edge. That row is erased in full, and then the sequence ends.
- R10: After row 1887 ends, the sequence finishes with `busy` = 0, `rac_n` = 1 and `row_idx` = 1887.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate tick, one clock wide |
| start | input | 1 | Start a sequence |
| erase_mode | input | 1 | 1 = erase, 0 = sample mode; sampled with start |
| start_addr | input | 16 | Start address; bits [15:5] give the row |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte; 0x80 requests a stop |
| rac_n | output | 1 | Active-low row-end marker |
| row_idx | output | 11 | Current row |
| busy | output | 1 | Sequence in progress |

## Verification
`busy` and `row_idx` respond on the first clock edge after a start. `rac_n` falls on the edge of the last high-phase tick. `rac_n` rises on the edge that ends the low phase, and that same edge moves `row_idx` forward or drops `busy`. The bench drives and samples on falling edges only, so that each output is read half a clock after the edge that changed it. It measures phase lengths by counting falling-edge samples at a constant level; with one tick on every clock, those counts equal the expected tick or clock counts exactly. The bench uses shortened row lengths, and it places stop commands in the high phase and in the erase low phase to tell the two stop rules apart.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_PLAY_HI,
        RS_PLAY_LO,
        RS_ERASE_HI,
        RS_ERASE_LO
    } rcs_state_e;

    localparam logic [7:0] RCS_STOP_CODE = 8'h80;
endpackage

// File: rtl/rcs_pulse_timer.sv
module rcs_pulse_timer #(
    parameter int PULSE_CLKS = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int TW = $clog2(PULSE_CLKS + 1);
    localparam logic [TW-1:0] T_LAST = TW'(PULSE_CLKS - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == T_LAST);

    // R6: while running, the count never passes the final value
    assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= T_LAST));
endmodule

// File: rtl/rcs_stop_track.sv
module rcs_stop_track
    import rcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    input  logic       in_erase_lo,
    input  logic       roll,
    output logic       stop_cur
);
    logic stop_hit;
    logic stop_nxt;

    assign stop_hit = cmd_valid && (cmd_byte == RCS_STOP_CODE);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stop_cur <= 1'b0;
            stop_nxt <= 1'b0;
        end else if (roll) begin
            stop_cur <= stop_nxt || stop_hit;
            stop_nxt <= 1'b0;
        end else if (stop_hit) begin
            if (in_erase_lo) stop_nxt <= 1'b1;
            else             stop_cur <= 1'b1;
        end
    end

    // R9: a stop seen during the erase low pulse moves onto the next row
    assert_stop_defer_R9: assert property (@(posedge clk) disable iff (rst)
        (stop_hit && in_erase_lo && !roll && !clear) |=> stop_nxt);
endmodule

// File: rtl/row_clock_seq.sv
module row_clock_seq
    import rcs_pkg::*;
#(
    parameter int ROW_TICKS    = 2048,
    parameter int LOW_TICKS    = 64,
    parameter int NUM_ROWS     = 1888,
    parameter int ADDR_W       = 16,
    parameter int ROW_SHIFT    = 5,
    parameter int CLK_MHZ      = 50,
    parameter int ERASE_LOW_NS = 250
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic                          start,
    input  logic                          erase_mode,
    input  logic [ADDR_W-1:0]             start_addr,
    input  logic                          cmd_valid,
    input  logic [7:0]                    cmd_byte,
    output logic                          rac_n,
    output logic [$clog2(NUM_ROWS)-1:0]   row_idx,
    output logic                          busy
);
    localparam int ROW_W     = $clog2(NUM_ROWS);
    localparam int SR_W      = ADDR_W - ROW_SHIFT;
    localparam int CNT_W     = $clog2(ROW_TICKS);
    localparam int ELOW_RAW  = (ERASE_LOW_NS * CLK_MHZ + 999) / 1000;
    localparam int ELOW      = (ELOW_RAW < 1) ? 1 : ELOW_RAW;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROW_TICKS - 1);
    localparam logic [CNT_W-1:0] HI_LAST  = CNT_W'(ROW_TICKS - LOW_TICKS - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    rcs_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [SR_W-1:0]  start_row;
    logic             unused_addr_low;
    logic             start_ok;
    logic             lo_done;
    logic             stop_cur;
    logic             row_end;
    logic             finish;

    assign start_row       = start_addr[ADDR_W-1:ROW_SHIFT];
    assign unused_addr_low = ^start_addr[ROW_SHIFT-1:0];
    assign start_ok        = start && (state == RS_IDLE) && (32'(start_row) < NUM_ROWS);

    assign row_end = ((state == RS_PLAY_LO) && tick && (cnt == CNT_LAST)) ||
                     ((state == RS_ERASE_LO) && lo_done);
    assign finish  = row_end && (stop_cur || (row_idx == LAST_ROW));

    rcs_pulse_timer #(.PULSE_CLKS(ELOW)) u_pulse (
        .clk  (clk),
        .rst  (rst),
        .run  (state == RS_ERASE_LO),
        .done (lo_done)
    );

    rcs_stop_track u_stop (
        .clk         (clk),
        .rst         (rst),
        .clear       (start_ok),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .in_erase_lo (state == RS_ERASE_LO),
        .roll        ((state == RS_ERASE_LO) && lo_done && !finish),
        .stop_cur    (stop_cur)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RS_IDLE:     if (start_ok) state_nx = erase_mode ? RS_ERASE_HI : RS_PLAY_HI;
            RS_PLAY_HI:  if (tick && cnt == HI_LAST) state_nx = RS_PLAY_LO;
            RS_PLAY_LO:  if (row_end) state_nx = finish ? RS_IDLE : RS_PLAY_HI;
            RS_ERASE_HI: if (tick && cnt == CNT_LAST) state_nx = RS_ERASE_LO;
            RS_ERASE_LO: if (row_end) state_nx = finish ? RS_IDLE : RS_ERASE_HI;
            default:     state_nx = RS_IDLE;
        endcase
    end

    // state register with row and tick counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RS_IDLE;
            cnt     <= '0;
            row_idx <= '0;
        end else begin
            state <= state_nx;
            if (start_ok) begin
                cnt     <= '0;
                row_idx <= ROW_W'(start_row);
            end else if (row_end) begin
                cnt <= '0;
                if (!finish) row_idx <= row_idx + 1'b1;
            end else if (tick && (state != RS_IDLE) && (state != RS_ERASE_LO)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            RS_IDLE:                  begin rac_n = 1'b1; busy = 1'b0; end
            RS_PLAY_HI, RS_ERASE_HI:  begin rac_n = 1'b1; busy = 1'b1; end
            RS_PLAY_LO, RS_ERASE_LO:  begin rac_n = 1'b0; busy = 1'b1; end
            default:                  begin rac_n = 1'b1; busy = 1'b0; end
        endcase
    end

    // checker: length of each erase low pulse
    logic [15:0] lo_len;
    always_ff @(posedge clk) begin
        if (rst)                        lo_len <= '0;
        else if (state == RS_ERASE_LO)  lo_len <= lo_len + 1'b1;
        else                            lo_len <= '0;
    end

    assert_row_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        32'(row_idx) < NUM_ROWS);
    assert_erase_pulse_len_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(state == RS_ERASE_LO) && state != RS_ERASE_LO) |-> (lo_len == 16'(ELOW)));
    assert_row_step_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && row_idx != $past(row_idx)) |->
            (row_idx == $past(row_idx) + 1'b1 && $rose(rac_n)));
    assert_end_on_marker_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(!rac_n) && rac_n));
    assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
        start_ok |=> (busy && row_idx == ROW_W'($past(start_row))));
    assert_idle_marker_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> rac_n);
endmodule

// File: tb/tb_row_clock_seq.sv
module tb_row_clock_seq;
    localparam int RT = 32;
    localparam int LT = 4;
    localparam int EL = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        start = 1'b0;
    logic        erase_mode = 1'b0;
    logic [15:0] start_addr = '0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_byte = '0;
    logic        rac_n;
    logic [10:0] row_idx;
    logic        busy;

    int total = 0;
    int bad = 0;
    int wd = 0;

    row_clock_seq #(.ROW_TICKS(RT), .LOW_TICKS(LT)) dut (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .erase_mode(erase_mode),
        .start_addr(start_addr), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .rac_n(rac_n), .row_idx(row_idx), .busy(busy)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (rac_n === lvl && n < 100000) begin
            n = n + 1;
            @(negedge clk);
        end
    endtask

    task automatic do_start(input int row, input logic lo_bits, input logic er);
        start_addr = 16'((row << 5) | (lo_bits ? 31 : 0));
        erase_mode = er;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_byte = b;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rac_n", int'(rac_n), 1);
        check("R1 busy", int'(busy), 0);
        check("R1 row", int'(row_idx), 0);
    endtask

    task automatic t_play_stop;
        int n;
        do_start(5, 1'b1, 1'b0);
        check("R2 row load", int'(row_idx), 5);
        check("R2 busy", int'(busy), 1);
        count_level(1'b1, n); check("R4 high ticks", n, RT - LT);
        count_level(1'b0, n); check("R4 low ticks", n, LT);
        check("R5 row step", int'(row_idx), 6);
        check("R5 busy", int'(busy), 1);
        do_start(40, 1'b0, 1'b0);
        check("R3 start while busy", int'(row_idx), 6);
        send_cmd(8'h80);
        count_level(1'b1, n);
        count_level(1'b0, n); check("R8 low ticks", n, LT);
        check("R8 busy cleared", int'(busy), 0);
        check("R8 row held", int'(row_idx), 6);
    endtask

    task automatic t_bad_start;
        do_start(1888, 1'b0, 1'b0);
        check("R3 out of range busy", int'(busy), 0);
        check("R3 out of range row", int'(row_idx), 6);
    endtask

    task automatic t_freeze_and_other_code;
        int n;
        tick = 1'b0;
        do_start(20, 1'b0, 1'b0);
        repeat (50) @(negedge clk);
        check("R4 frozen rac", int'(rac_n), 1);
        check("R4 frozen row", int'(row_idx), 20);
        send_cmd(8'h81);
        tick = 1'b1;
        count_level(1'b1, n); check("R4 high after freeze", n, RT - LT);
        count_level(1'b0, n);
        check("R8 other code ignored busy", int'(busy), 1);
        check("R8 other code ignored row", int'(row_idx), 21);
        send_cmd(8'h80);
        count_level(1'b1, n);
        count_level(1'b0, n);
        check("R8 stop row 21", int'(row_idx), 21);
        check("R8 stop busy", int'(busy), 0);
    endtask

    task automatic t_erase;
        int n;
        do_start(10, 1'b1, 1'b1);
        check("R2 erase row", int'(row_idx), 10);
        count_level(1'b1, n); check("R6 erase high ticks", n, RT);
        count_level(1'b0, n); check("R6 erase low clocks", n, EL);
        check("R7 erase step", int'(row_idx), 11);
        count_level(1'b1, n);
        send_cmd(8'h80);
        count_level(1'b0, n);
        check("R9 next row starts", int'(row_idx), 12);
        check("R9 still busy", int'(busy), 1);
        count_level(1'b1, n); check("R9 full row", n, RT);
        count_level(1'b0, n); check("R6 low clocks", n, EL);
        check("R9 ended busy", int'(busy), 0);
        check("R9 ended row", int'(row_idx), 12);
    endtask

    task automatic t_last_row;
        int n;
        do_start(1886, 1'b0, 1'b1);
        count_level(1'b1, n);
        count_level(1'b0, n);
        check("R10 reach last", int'(row_idx), 1887);
        count_level(1'b1, n);
        count_level(1'b0, n);
        check("R10 busy", int'(busy), 0);
        check("R10 rac_n", int'(rac_n), 1);
        check("R10 row", int'(row_idx), 1887);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_play_stop();
        t_bad_start();
        t_freeze_and_other_code();
        t_erase();
        t_last_row();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule